// File: doc/BRIEF.md
# Three-State Counting Sequencer

This block pairs a small sequencing controller with a counting datapath. After reset it rests in an idle state. A one-cycle start request clears a counter and a completion flag, and the block then enters a counting state. While counting, the counter advances once per clock and a tracking flag follows one counter bit. When two chosen counter bits are both high, the sequencer moves to a finishing state. There it raises the completion flag, and it returns to idle on the next clock.

The controller keeps a two-bit binary state code, and a decoder turns that code into separate state-select lines. One of the four codes is never entered. Every decision (the start test, the flag update and the exit test) uses register values from before the current edge. This means the step that leaves the counting state also performs one last increment. Starting from a cleared counter, the block therefore reaches the finishing state with the counter at 7 and the tracking flag at 1.

Top module: `asm_counter_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `state_code` to 00 (idle) and sets `cnt_a`, `flag_e` and `flag_f` to 0.
- R2: In idle (code 00) with `start_s` low, the next edge keeps code 00 and leaves `cnt_a`, `flag_e` and `flag_f` unchanged.
- R3: In idle with `start_s` high, the next edge sets code 01 (counting), clears `cnt_a` and `flag_f`, and leaves `flag_e` unchanged.
- R4: In counting (code 01), every edge adds one to `cnt_a`, modulo 2^CNT_W.
- R5: In counting, every edge loads `flag_e` with bit 1 of `cnt_a` (bit 0 being the least significant) as it was before that edge.
- R6: In counting, if bits 1 and 2 of `cnt_a` were both 1 before the edge, the next code is 11 (finishing). Otherwise it stays 01. `start_s` has no effect in this state.
- R7: In finishing (code 11), the next edge sets `flag_f` to 1 and code 00. `cnt_a` and `flag_e` keep their values.
- R8: Exactly one of `st_t0`, `st_t1`, `st_t2` is high, and it matches `state_code` 00, 01 and 11 respectively. The spare code 10 is followed by code 00.
- R9: A start taken from idle reaches code 11 with `cnt_a` equal to 7 and `flag_e` equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_s | input | 1 | Start request, sampled in idle |
| cnt_a | output | CNT_W | Counter value |
| flag_e | output | 1 | Tracking flag, follows a counter bit while counting |
| flag_f | output | 1 | Completion flag |
| state_code | output | 2 | Binary state code (00 idle, 01 counting, 11 finishing) |
| st_t0 | output | 1 | Idle select |
| st_t1 | output | 1 | Counting select |
| st_t2 | output | 1 | Finishing select |

## Verification
The state code and all datapath registers are visible at the ports. A wrong next-state decision therefore shows on `state_code` and the select lines on the very next edge. A counter or flag updated in the wrong state shows on `cnt_a`, `flag_e` or `flag_f` in that same cycle. A decision that sampled the post-increment counter would leave the counting state one cycle early, so the finishing state would be reached with `cnt_a` at 6 instead of 7. The bench compares every cycle of a random start-pulse trace, with occasional resets, against a stepwise reference. On top of that trace it runs directed start and held-start cases.

// File: rtl/asm_ctl_pkg.sv
package asm_ctl_pkg;
   localparam int unsigned ST_W    = 2;
   localparam int unsigned ST_CODES = 1 << ST_W;

   typedef enum logic [ST_W-1:0] {
      ST_IDLE  = 2'b00,
      ST_COUNT = 2'b01,
      ST_SPARE = 2'b10,
      ST_DONE  = 2'b11
   } asm_state_e;
endpackage

// File: rtl/asm_seq_ctrl.sv
module asm_seq_ctrl
   import asm_ctl_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic            start_i,
   input  logic            sel_idle_i,
   input  logic            sel_count_i,
   input  logic            sel_spare_i,
   input  logic            exit_i,
   output logic [ST_W-1:0] code_o
);
   logic d_hi;
   logic d_lo;

   // Next-state equations, one per state bit
   always_comb begin
      d_hi = sel_count_i & exit_i;
      d_lo = (sel_idle_i & start_i) | sel_count_i;
      if (sel_spare_i) begin
         d_hi = 1'b0;
         d_lo = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) code_o <= ST_IDLE;
      else     code_o <= {d_hi, d_lo};
   end
endmodule

// File: rtl/asm_state_dec.sv
module asm_state_dec
   import asm_ctl_pkg::*;
(
   input  logic [ST_W-1:0]     code_i,
   output logic [ST_CODES-1:0] sel_o
);
   for (genvar k = 0; k < ST_CODES; k++) begin : g_line
      assign sel_o[k] = (code_i == ST_W'(k));
   end
endmodule

// File: rtl/asm_datapath.sv
module asm_datapath #(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned E_IDX  = 1,
   parameter int unsigned X_LO   = 1,
   parameter int unsigned X_HI   = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             sel_idle_i,
   input  logic             sel_count_i,
   input  logic             sel_done_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             flag_e_o,
   output logic             flag_f_o,
   output logic             exit_o
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   logic clr;
   assign clr    = sel_idle_i & start_i;
   assign exit_o = cnt_o[X_LO] & cnt_o[X_HI];

   always_ff @(posedge clk) begin
      if (rst)              cnt_o <= '0;
      else if (clr)         cnt_o <= '0;
      else if (sel_count_i) cnt_o <= cnt_o + STEP;
   end

   always_ff @(posedge clk) begin
      if (rst)              flag_e_o <= 1'b0;
      else if (sel_count_i) flag_e_o <= cnt_o[E_IDX];
   end

   always_ff @(posedge clk) begin
      if (rst)             flag_f_o <= 1'b0;
      else if (clr)        flag_f_o <= 1'b0;
      else if (sel_done_i) flag_f_o <= 1'b1;
   end
endmodule

// File: rtl/asm_counter_ctrl.sv
module asm_counter_ctrl
   import asm_ctl_pkg::*;
#(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned E_IDX = 1,
   parameter int unsigned X_LO  = 1,
   parameter int unsigned X_HI  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_s,
   output logic [CNT_W-1:0] cnt_a,
   output logic             flag_e,
   output logic             flag_f,
   output logic [1:0]       state_code,
   output logic             st_t0,
   output logic             st_t1,
   output logic             st_t2
);
   if (E_IDX >= CNT_W || X_LO >= CNT_W || X_HI >= CNT_W || X_LO == X_HI) begin : g_bad_param
      $error("asm_counter_ctrl: bit index parameters out of range");
   end

   logic [ST_W-1:0]     code;
   logic [ST_CODES-1:0] sel;
   logic                exit_w;

   asm_seq_ctrl u_ctrl (
      .clk(clk), .rst(rst), .start_i(start_s),
      .sel_idle_i(sel[ST_IDLE]), .sel_count_i(sel[ST_COUNT]),
      .sel_spare_i(sel[ST_SPARE]), .exit_i(exit_w), .code_o(code)
   );

   asm_state_dec u_dec (.code_i(code), .sel_o(sel));

   asm_datapath #(.CNT_W(CNT_W), .E_IDX(E_IDX), .X_LO(X_LO), .X_HI(X_HI)) u_dp (
      .clk(clk), .rst(rst), .start_i(start_s),
      .sel_idle_i(sel[ST_IDLE]), .sel_count_i(sel[ST_COUNT]),
      .sel_done_i(sel[ST_DONE]), .cnt_o(cnt_a), .flag_e_o(flag_e),
      .flag_f_o(flag_f), .exit_o(exit_w)
   );

   assign state_code = code;
   assign st_t0      = sel[ST_IDLE];
   assign st_t1      = sel[ST_COUNT];
   assign st_t2      = sel[ST_DONE];
endmodule

module asm_counter_ctrl_chk #(
   parameter int unsigned CNT_W = 4,
   parameter int unsigned E_IDX = 1,
   parameter int unsigned X_LO  = 1,
   parameter int unsigned X_HI  = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             start_s,
   input logic [CNT_W-1:0] cnt_a,
   input logic             flag_e,
   input logic             flag_f,
   input logic [1:0]       state_code,
   input logic             st_t0,
   input logic             st_t1,
   input logic             st_t2
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (state_code == 2'b00 && cnt_a == '0 && !flag_e && !flag_f));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (st_t0 && !start_s) |=> (st_t0 && $stable(cnt_a) && $stable(flag_e) && $stable(flag_f)));

   p_start_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (st_t0 && start_s) |=> (st_t1 && cnt_a == '0 && !flag_f && $stable(flag_e)));

   p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
      st_t1 |=> (cnt_a == $past(cnt_a) + ONE));

   p_track_e_r5: assert property (@(posedge clk) disable iff (rst)
      st_t1 |=> (flag_e == $past(cnt_a[E_IDX])));

   p_exit_r6: assert property (@(posedge clk) disable iff (rst)
      (st_t1 && cnt_a[X_LO] && cnt_a[X_HI]) |=> st_t2);

   p_stay_r6: assert property (@(posedge clk) disable iff (rst)
      (st_t1 && !(cnt_a[X_LO] && cnt_a[X_HI])) |=> st_t1);

   p_done_r7: assert property (@(posedge clk) disable iff (rst)
      st_t2 |=> (st_t0 && flag_f && $stable(cnt_a) && $stable(flag_e)));

   p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
      ($onehot({st_t2, st_t1, st_t0}) && (st_t0 == (state_code == 2'b00))
       && (st_t1 == (state_code == 2'b01)) && (st_t2 == (state_code == 2'b11))));
endmodule

bind asm_counter_ctrl asm_counter_ctrl_chk #(
   .CNT_W(CNT_W), .E_IDX(E_IDX), .X_LO(X_LO), .X_HI(X_HI)
) u_chk (
   .clk(clk), .rst(rst), .start_s(start_s), .cnt_a(cnt_a), .flag_e(flag_e),
   .flag_f(flag_f), .state_code(state_code), .st_t0(st_t0), .st_t1(st_t1), .st_t2(st_t2)
);

// File: tb/asm_counter_ctrl_test.sv
module asm_counter_ctrl_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start_s = 1'b0;
   logic [3:0] cnt_a;
   logic       flag_e, flag_f;
   logic [1:0] state_code;
   logic       st_t0, st_t1, st_t2;

   int errors = 0;
   int checks = 0;

   // reference model state
   logic [1:0] m_st = 2'b00;
   logic [3:0] m_a  = 4'd0;
   logic       m_e  = 1'b0;
   logic       m_f  = 1'b0;

   always #2 clk = ~clk;

   asm_counter_ctrl uut (
      .clk(clk), .rst(rst), .start_s(start_s), .cnt_a(cnt_a), .flag_e(flag_e),
      .flag_f(flag_f), .state_code(state_code), .st_t0(st_t0), .st_t1(st_t1), .st_t2(st_t2)
   );

   function automatic logic [1:0] ref_next(input logic [1:0] st, input logic s, input logic [3:0] a);
      case (st)
         2'b00:   return s ? 2'b01 : 2'b00;
         2'b01:   return (a[1] && a[2]) ? 2'b11 : 2'b01;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic [2:0] ref_sel(input logic [1:0] st);
      case (st)
         2'b00:   return 3'b001;
         2'b01:   return 3'b010;
         2'b11:   return 3'b100;
         default: return 3'b000;
      endcase
   endfunction

   task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare(input string rs, input string ra, input string re, input string rf);
      chk(state_code == m_st, rs, "state_code", state_code, m_st);
      chk(cnt_a == m_a, ra, "cnt_a", cnt_a, m_a);
      chk(flag_e == m_e, re, "flag_e", flag_e, m_e);
      chk(flag_f == m_f, rf, "flag_f", flag_f, m_f);
      chk({st_t2, st_t1, st_t0} == ref_sel(m_st), "R8", "select lines",
          {st_t2, st_t1, st_t0}, ref_sel(m_st));
   endtask

   // one clock: drive at negedge, update model at posedge, compare at next negedge
   task automatic step(input logic s, input logic r);
      logic [1:0] ps;
      string rs, ra, re, rf;
      ps = m_st;
      start_s = s;
      rst = r;
      @(posedge clk);
      if (r) begin
         m_st = 2'b00; m_a = 4'd0; m_e = 1'b0; m_f = 1'b0;
      end else begin
         case (ps)
            2'b00: if (s) begin m_a = 4'd0; m_f = 1'b0; end
            2'b01: begin m_e = m_a[1]; m_a = m_a + 4'd1; end
            2'b11: m_f = 1'b1;
            default: ;
         endcase
         m_st = ref_next(ps, s, (ps == 2'b01) ? m_a - 4'd1 : m_a);
      end
      @(negedge clk);
      if (r) begin
         rs = "R1"; ra = "R1"; re = "R1"; rf = "R1";
      end else if (ps == 2'b00) begin
         rs = s ? "R3" : "R2"; ra = s ? "R3" : "R2"; re = s ? "R3" : "R2"; rf = s ? "R3" : "R2";
      end else if (ps == 2'b01) begin
         rs = "R6"; ra = "R4"; re = "R5"; rf = "R6";
      end else begin
         rs = "R7"; ra = "R7"; re = "R7"; rf = "R7";
      end
      compare(rs, ra, re, rf);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int seed;
      int n;
      seed = 32'h5EED_1234;
      void'($urandom(seed));
      @(negedge clk);
      // R1: reset state
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
      // R2: idle with no start
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
      // R3 then R9: single start pulse from cleared counter
      step(1'b1, 1'b0);
      n = 0;
      while (state_code != 2'b11 && n < 40) begin
         step(1'b0, 1'b0);
         n++;
      end
      chk(cnt_a == 4'd7, "R9", "cnt_a on entering finish", cnt_a, 7);
      chk(flag_e == 1'b1, "R9", "flag_e on entering finish", flag_e, 1);
      chk(n == 7, "R9", "counting cycles", n, 7);
      step(1'b0, 1'b0);  // R7: finish to idle with flag_f set
      // R6: start held high through counting has no effect
      for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
      // reset in mid-count (R1)
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      // random start pulses and rare resets
      for (int i = 0; i < 2000; i++) begin
         step(($urandom % 4) == 0, ($urandom % 150) == 0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule